// File: doc/BRIEF.md
# Two-Channel Fan Tachometer Period Counter

This block measures how fast two fans spin. Each fan gives a tachometer pulse train with two pulses per revolution. For each channel the block counts ticks of a prescaled low-frequency reference during one tach period, from one rising edge to the next. The count clock comes from a nominal 32.768 kHz reference. It is selected per channel from two reference tick inputs, divided by 1, 2, 4 or 8, and optionally doubled. A small count means a fast fan. A count of 255 means the fan is stalled or too slow to measure.

The block runs on one system clock. Both reference sources enter as single-cycle enable pulses at twice the nominal reference rate, so the doubler can be built without a second clock. The tach inputs are asynchronous and are synchronized inside the block. On every qualified rising tach edge, the running count is copied into a readable result, and then the counter and its prescaler restart. Each channel has a preload/limit register. Writing it also restarts that channel's counter. A slow-fan condition sets a sticky alarm that software clears by writing a one. Two per-channel enables gate the alarm onto a power-management event line and a system-management event line.

There is no streaming data path: results, configuration and alarms are plain level signals. Writes are single-cycle strobes with no back-pressure.

Top module: `fan_tach_meter`

## Requirements
- R1: The 8-bit control register resets to 0 and loads `ctrl_wdata` when `ctrl_we` is high. Channel 0 takes its divisor code from bits 7:6 and channel 1 from bits 5:4. A code c gives a division by 2^c, so codes 0,1,2,3 give 1,2,4,8.
- R2: Bit 3 (channel 0) and bit 2 (channel 1) double the count rate when 1. One count tick occurs every N reference ticks, where N = 2^(c+1) when the bit is 0 and N = 2^c when it is 1.
- R3: Bit 1 (channel 0) and bit 0 (channel 1) select the reference tick source: 0 selects `ref_tick_ext` and 1 selects `ref_tick_int`.
- R4: The tach input passes through a two-flop synchronizer, and only a 0-to-1 transition of the synchronized signal is a pulse. On each pulse the counter and prescaler restart. If tach rising edges arrive P cycles apart and the selected reference ticks every cycle, the measured count is floor((P-1)/N).
- R5: The counter saturates at 255 and holds there until the next pulse or preload write. It never wraps.
- R6: A write to a channel's preload/limit register (`lim_we` bit = channel) stores `lim_wdata` and restarts that channel's counter and prescaler.
- R7: On each pulse the counter value is latched into that channel's byte of `count_o` (channel 0 in bits 7:0). It appears three clock edges after the tach input rises.
- R8: The alarm of a channel is set when a latched count is greater than or equal to its limit, or when its counter is at 255. It stays set until a one is written to `alarm_clr`. If a set and a clear arrive together, the set wins.
- R9: `pme_o` and `smi_o` of a channel are high exactly when its alarm is set and the matching enable is high.
- R10: After reset, the counts and latched results are 0, the limits are 255, and all alarms and events are low.
- R11: The two channels are independent. Each one uses only its own control fields, tach input and limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_tick_ext | input | 1 | Reference tick source 0 (pulses at twice the nominal rate) |
| ref_tick_int | input | 1 | Reference tick source 1 |
| tach_i | input | 2 | Asynchronous tach inputs, one per channel |
| ctrl_we | input | 1 | Control register write strobe |
| ctrl_wdata | input | 8 | Control register write data |
| ctrl_o | output | 8 | Control register readback |
| lim_we | input | 2 | Per-channel preload/limit write strobe |
| lim_wdata | input | 8 | Preload/limit write data |
| alarm_clr | input | 2 | Per-channel write-one-to-clear of the alarm |
| pme_en | input | 2 | Per-channel power-management event enable |
| smi_en | input | 2 | Per-channel system-management event enable |
| count_o | output | 16 | Latched period counts, channel 0 in bits 7:0 |
| alarm_o | output | 2 | Sticky slow-fan alarms |
| pme_o | output | 2 | Power-management event lines |
| smi_o | output | 2 | System-management event lines |

## Verification
The assertions watch the invariants that hold on every cycle:
- the counter never wraps past 255, and moves by at most one step unless it restarts;
- each pulse clears the counter and latches its prior value;
- a synchronized pulse lasts exactly one cycle;
- a saturated counter always raises the alarm, and an alarm persists until it is cleared.

Only the bench scenarios can show the arithmetic. They check the count for each divisor, doubler and source combination, the bit positions of both channels' fields, and the alarm threshold at exactly equal and one-above values. They also check that a preload write in mid-period shortens the next measured count.

// File: rtl/fan_tach_pkg.sv
package fan_tach_pkg;
  localparam int NUM_CH = 2;
  localparam int DIV_W  = 2;
  localparam int CTRL_W = 8;

  typedef struct packed {
    logic [DIV_W-1:0] div;
    logic             dbl;
    logic             src;
  } chan_cfg_t;

  // Field layout of the shared control byte (positions are decoded per channel).
  function automatic chan_cfg_t cfg_of(input logic [CTRL_W-1:0] c, input int ch);
    chan_cfg_t r;
    r.div = c[CTRL_W-1-DIV_W*ch -: DIV_W];
    r.dbl = c[3-ch];
    r.src = c[1-ch];
    return r;
  endfunction
endpackage

// File: rtl/fan_tach_sync.sv
module fan_tach_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);
  logic [STAGES:0] sh;

  always_ff @(posedge clk) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[STAGES-1:0], din};
  end

  assign rise = sh[STAGES-1] & ~sh[STAGES];

  // R4: a qualified pulse never lasts two cycles
  p_single_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
endmodule

// File: rtl/fan_tach_prescaler.sv
module fan_tach_prescaler
  import fan_tach_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             restart,
  input  logic [DIV_W-1:0] div_code,
  input  logic             dbl,
  output logic             cnt_en
);
  localparam int PRE_W = 1 << DIV_W;

  logic [PRE_W:0]   span;
  logic [PRE_W-1:0] last;
  logic [PRE_W-1:0] pre;
  logic             hit;

  always_comb begin
    span = ({{PRE_W{1'b0}}, 1'b1} << (div_code + 1)) >> dbl;
    last = PRE_W'(span - 1'b1);
  end

  assign hit    = tick && (pre >= last);
  assign cnt_en = hit && !restart;

  always_ff @(posedge clk) begin
    if (!rst_n)       pre <= '0;
    else if (restart) pre <= '0;
    else if (tick)    pre <= hit ? '0 : pre + 1'b1;
  end

  // R2: count enables only come from a reference tick
  p_en_needs_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_en |-> tick);
  // R6: a restart always brings the prescaler back to phase zero
  p_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> pre == '0);
endmodule

// File: rtl/fan_tach_channel.sv
module fan_tach_channel
  import fan_tach_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             tach,
  input  chan_cfg_t        cfg,
  input  logic             lim_we,
  input  logic [CNT_W-1:0] lim_wdata,
  input  logic             alarm_clr,
  output logic [CNT_W-1:0] count_o,
  output logic             alarm_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             rise;
  logic             cnt_en;
  logic             set_alarm;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] latch_q;
  logic [CNT_W-1:0] limit_q;
  logic             alarm_q;

  fan_tach_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(tach), .rise(rise)
  );

  fan_tach_prescaler u_pre (
    .clk(clk), .rst_n(rst_n), .tick(tick), .restart(rise | lim_we),
    .div_code(cfg.div), .dbl(cfg.dbl), .cnt_en(cnt_en)
  );

  assign set_alarm = (rise && (cnt >= limit_q)) || (cnt == CNT_MAX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= '0;
      latch_q <= '0;
      limit_q <= CNT_MAX;
      alarm_q <= 1'b0;
    end else begin
      if (rise)   latch_q <= cnt;
      if (lim_we) limit_q <= lim_wdata;
      if (rise || lim_we)
        cnt <= '0;
      else if (cnt_en && (cnt != CNT_MAX))
        cnt <= cnt + 1'b1;
      alarm_q <= set_alarm | (alarm_q & ~alarm_clr);
    end
  end

  assign count_o = latch_q;
  assign alarm_o = alarm_q;

  p_no_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == CNT_MAX) && !rise && !lim_we |=> cnt == CNT_MAX);
  p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !rise && !lim_we |=> (cnt == $past(cnt)) || (cnt == $past(cnt) + 1'b1));
  p_clear_on_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> cnt == '0);
  p_latch_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> count_o == $past(cnt));
  p_lim_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    lim_we |=> cnt == '0);
  p_sat_alarm_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt == CNT_MAX |=> alarm_o);
  p_alarm_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_o && !alarm_clr |=> alarm_o);
endmodule

// File: rtl/fan_tach_meter.sv
module fan_tach_meter
  import fan_tach_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ref_tick_ext,
  input  logic                    ref_tick_int,
  input  logic [NUM_CH-1:0]       tach_i,
  input  logic                    ctrl_we,
  input  logic [CTRL_W-1:0]       ctrl_wdata,
  output logic [CTRL_W-1:0]       ctrl_o,
  input  logic [NUM_CH-1:0]       lim_we,
  input  logic [CNT_W-1:0]        lim_wdata,
  input  logic [NUM_CH-1:0]       alarm_clr,
  input  logic [NUM_CH-1:0]       pme_en,
  input  logic [NUM_CH-1:0]       smi_en,
  output logic [NUM_CH*CNT_W-1:0] count_o,
  output logic [NUM_CH-1:0]       alarm_o,
  output logic [NUM_CH-1:0]       pme_o,
  output logic [NUM_CH-1:0]       smi_o
);
  logic [CTRL_W-1:0] ctrl_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (ctrl_we) ctrl_q <= ctrl_wdata;
  end
  assign ctrl_o = ctrl_q;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    chan_cfg_t cfg;
    logic      tick;

    assign cfg  = cfg_of(ctrl_q, ch);
    assign tick = cfg.src ? ref_tick_int : ref_tick_ext;

    fan_tach_channel #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) u_chan (
      .clk(clk), .rst_n(rst_n), .tick(tick), .tach(tach_i[ch]), .cfg(cfg),
      .lim_we(lim_we[ch]), .lim_wdata(lim_wdata), .alarm_clr(alarm_clr[ch]),
      .count_o(count_o[ch*CNT_W +: CNT_W]), .alarm_o(alarm_o[ch])
    );

    assign pme_o[ch] = alarm_o[ch] & pme_en[ch];
    assign smi_o[ch] = alarm_o[ch] & smi_en[ch];
  end

  // R9: no event line is high while its alarm is low
  p_evt_alarm_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((pme_o | smi_o) & ~alarm_o) == '0);
endmodule

// File: tb/test_fan_tach_meter.sv
module test_fan_tach_meter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ref_tick_ext = 1'b1;
  logic        ref_tick_int = 1'b0;
  logic [1:0]  tach_i = '0;
  logic        ctrl_we = 1'b0;
  logic [7:0]  ctrl_wdata = '0;
  logic [7:0]  ctrl_o;
  logic [1:0]  lim_we = '0;
  logic [7:0]  lim_wdata = '0;
  logic [1:0]  alarm_clr = '0;
  logic [1:0]  pme_en = '0;
  logic [1:0]  smi_en = '0;
  logic [15:0] count_o;
  logic [1:0]  alarm_o, pme_o, smi_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  fan_tach_meter i_fan_tach_meter (
    .clk(clk), .rst_n(rst_n), .ref_tick_ext(ref_tick_ext), .ref_tick_int(ref_tick_int),
    .tach_i(tach_i), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata), .ctrl_o(ctrl_o),
    .lim_we(lim_we), .lim_wdata(lim_wdata), .alarm_clr(alarm_clr),
    .pme_en(pme_en), .smi_en(smi_en), .count_o(count_o), .alarm_o(alarm_o),
    .pme_o(pme_o), .smi_o(smi_o)
  );

  localparam int VEC_N = 6;
  localparam logic [7:0] V_CTRL [VEC_N] = '{8'h00, 8'h68, 8'hC4, 8'h91, 8'h32, 8'h0C};
  localparam int         V_PER  [VEC_N] = '{60, 100, 200, 90, 300, 400};

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int expect_cnt(input logic [7:0] c, input int ch, input int per);
    int code, dbl, src, n, v;
    code = (ch == 0) ? int'(c[7:6]) : int'(c[5:4]);
    dbl  = (ch == 0) ? int'(c[3]) : int'(c[2]);
    src  = (ch == 0) ? int'(c[1]) : int'(c[0]);
    if (src != 0) return 0;          // ref_tick_int is held low here
    n = (2 << code) >> dbl;
    v = (per - 1) / n;
    return (v > 255) ? 255 : v;
  endfunction

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_ctrl(input logic [7:0] v);
    ctrl_we = 1'b1; ctrl_wdata = v; cyc(1); ctrl_we = 1'b0;
  endtask

  task automatic set_lim(input logic [1:0] which, input logic [7:0] v);
    lim_we = which; lim_wdata = v; cyc(1); lim_we = '0;
    alarm_clr = 2'b11; cyc(1); alarm_clr = '0;
  endtask

  // three full periods, then the closing rising edge; the count is read 5 cycles on
  task automatic measure(input int per);
    for (int k = 0; k < 3; k++) begin
      tach_i = 2'b11; cyc(per / 2);
      tach_i = 2'b00; cyc(per - per / 2);
    end
    tach_i = 2'b11; cyc(5);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    // R10 reset state
    chk("R10 count", int'(count_o), 0);
    chk("R10 alarm", int'(alarm_o), 0);
    chk("R10 events", int'({pme_o, smi_o}), 0);
    chk("R1 ctrl reset", int'(ctrl_o), 0);

    // R1 R2 R3 R4 R7 R11 table of configurations
    for (int v = 0; v < VEC_N; v++) begin
      tach_i = 2'b00;
      set_ctrl(V_CTRL[v]);
      chk("R1 ctrl readback", int'(ctrl_o), int'(V_CTRL[v]));
      measure(V_PER[v]);
      chk("R4 R11 ch0 count", int'(count_o[7:0]), expect_cnt(V_CTRL[v], 0, V_PER[v]));
      chk("R4 R11 ch1 count", int'(count_o[15:8]), expect_cnt(V_CTRL[v], 1, V_PER[v]));
    end

    // R8 R9 alarm threshold: ch0 N=1, ch1 N=2
    tach_i = 2'b00;
    set_ctrl(8'h08);
    pme_en = 2'b01; smi_en = 2'b10;
    set_lim(2'b11, 8'd50);
    measure(40);
    chk("R8 below limit", int'(alarm_o), 0);
    tach_i = 2'b00;
    measure(80);
    chk("R8 ch0 count", int'(count_o[7:0]), 79);
    chk("R8 above limit", int'(alarm_o), 1);
    chk("R9 pme", int'(pme_o), 1);
    chk("R9 smi", int'(smi_o), 0);
    alarm_clr = 2'b01; cyc(1); alarm_clr = '0;
    chk("R8 w1c", int'(alarm_o[0]), 0);
    chk("R9 pme after clear", int'(pme_o), 0);
    tach_i = 2'b00;
    set_lim(2'b01, 8'd80);
    measure(80);
    chk("R8 one below limit", int'(alarm_o[0]), 0);
    tach_i = 2'b00;
    set_lim(2'b01, 8'd79);
    measure(80);
    chk("R8 equal to limit", int'(alarm_o[0]), 1);

    // R5 saturation: ch0 N=16, period far longer than 255 counts
    tach_i = 2'b00;
    set_ctrl(8'hC0);
    set_lim(2'b01, 8'd200);
    tach_i = 2'b11; cyc(2500);
    tach_i = 2'b00; cyc(1800);
    chk("R5 R8 saturation alarm", int'(alarm_o[0]), 1);
    tach_i = 2'b11; cyc(5);
    chk("R5 saturated count", int'(count_o[7:0]), 255);

    // R6 preload write in mid-period restarts the count: ch0 N=1, P=100, write at 40
    tach_i = 2'b00;
    set_ctrl(8'h08);
    cyc(5);
    tach_i = 2'b01;
    for (int i = 1; i < 100; i++) begin
      @(negedge clk);
      if (i == 40) begin lim_we = 2'b01; lim_wdata = 8'd200; end
      if (i == 41) lim_we = 2'b00;
      if (i == 50) tach_i = 2'b00;
    end
    @(negedge clk);
    tach_i = 2'b01;
    cyc(5);
    chk("R6 preload restart", int'(count_o[7:0]), 61);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule